// File: doc/BRIEF.md
# 8B/10B Receive Link Bring-Up Controller

This block sequences the bring-up of an 8B/10B receive link. One link state machine steps through reset, waiting for the transceivers, code group synchronisation and user data. Each lane has its own tracker that watches the decoded beats for the comma control character. The block drives the active-low synchronisation request lines toward the transmitters, an enable for character alignment in the transceivers and a flag that marks the received stream as valid user data.

The synchronisation request is released only when every enabled lane has synchronised and a timing boundary arrives. In subclass 0 that boundary is the next frame boundary. In subclass 1 it is the next multiframe clock boundary, and only after the external timing reference has been captured. After release, a per-lane counter measures in octets how long each lane takes to show its first non-comma character. This shows how long each transmitter takes to react.

Top module: `rx_link_ctrl`

## Requirements
- R1: `link_state` encodes RESET=0, WAIT_FOR_PHY=1, CGS=2, DATA=3. After `rst` the state is RESET and every lane tracker is INIT. `rst` is synchronous and active high.
- R2: While `link_en` is low the state becomes RESET at the next clock edge from any state, and all lane trackers become INIT. They stay there whatever the other inputs do. In RESET with `link_en` high the state moves to WAIT_FOR_PHY.
- R3: WAIT_FOR_PHY moves to CGS only at an edge where every lane not set in `lane_off` has its `phy_rdy` bit high.
- R4: Each `sync_n` bit whose `link_mask` bit is 1 is held high. All other `sync_n` bits are low in every state except DATA and high in DATA, so they always switch together. `align_en` is high only in CGS.
- R5: Lane tracker codes are INIT=0, CHECK=1 and DATA=2 (2 bits per lane, lane 0 lowest). A comma is an octet equal to 0xBC with its `beat_kflag` bit set. Octet o of lane i is `beat_data[32i+8o +: 8]` with flag `beat_kflag[4i+o]`, and octets are taken lowest first. Trackers change only while the link state is CGS. A comma moves INIT to CHECK. Four consecutive commas (counting the first) reach DATA. A non-comma in CHECK returns to INIT. DATA holds.
- R6: In subclass 0 (`subclass1`=0), CGS moves to DATA at an edge where `frame_edge` is high and every enabled lane's tracker is already DATA.
- R7: In subclass 1, CGS moves to DATA only at an edge where `lmfc_edge` and `sysref_seen` are both high and every enabled lane is in DATA. `frame_edge` alone does not release the link.
- R8: `data_valid` is high exactly while the state is DATA. It stays high until `link_en` falls or `rst` is applied.
- R9: A lane with its `lane_off` bit set is held in INIT and is left out of every all-lanes condition.
- R10: From the first edge in DATA, lane i counts octets in `lane_lat[12i +: 12]` until its first non-comma octet. The count equals the number of octets before that one, and then it holds. The count clears outside DATA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| link_en | input | 1 | Link enable |
| subclass1 | input | 1 | 1 selects subclass 1 release rule |
| sysref_seen | input | 1 | Timing reference has been captured |
| lmfc_edge | input | 1 | Multiframe clock boundary pulse |
| frame_edge | input | 1 | Frame boundary pulse |
| lane_off | input | LANES | Per-lane disable |
| phy_rdy | input | LANES | Per-lane transceiver ready |
| beat_data | input | LANES*32 | Decoded octets, four per lane |
| beat_kflag | input | LANES*4 | Control-character flag per octet |
| link_mask | input | LINKS | Per-line mask for sync_n |
| sync_n | output | LINKS | Active-low synchronisation request |
| align_en | output | 1 | Transceiver character alignment enable |
| data_valid | output | 1 | User data valid |
| link_state | output | 2 | Link state code |
| lane_state | output | LANES*2 | Per-lane tracker code |
| lane_lat | output | LANES*12 | Per-lane octet latency count |

## Verification
The trackers are given comma runs that break on the last octet of a beat, and runs that start on the last octet of one beat and finish inside the next. These separate per-octet counting from per-beat counting. Release is tried with a frame pulse alone, a multiframe pulse without the captured reference, and both together, which separates the two subclass rules. A disabled lane fed with commas, a lane that is not ready, and disabling mid-bring-up show whether masked lanes and the enable are honoured. Latency is measured with a first non-comma at octet 0 on one lane and octet 2 in the second beat on the other.

// File: rtl/rx_link_ctrl.sv
module rx_link_ctrl #(
  parameter int LANES  = 2,
  parameter int LINKS  = 2,
  parameter int OCTETS = 4,
  parameter int LAT_W  = 12,
  parameter int K_RUN  = 4,
  parameter logic [7:0] K_CODE = 8'hBC
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    link_en,
  input  logic                    subclass1,
  input  logic                    sysref_seen,
  input  logic                    lmfc_edge,
  input  logic                    frame_edge,
  input  logic [LANES-1:0]        lane_off,
  input  logic [LANES-1:0]        phy_rdy,
  input  logic [LANES*OCTETS*8-1:0] beat_data,
  input  logic [LANES*OCTETS-1:0] beat_kflag,
  input  logic [LINKS-1:0]        link_mask,
  output logic [LINKS-1:0]        sync_n,
  output logic                    align_en,
  output logic                    data_valid,
  output logic [1:0]              link_state,
  output logic [LANES*2-1:0]      lane_state,
  output logic [LANES*LAT_W-1:0]  lane_lat
);
  localparam int BEAT_W = OCTETS * 8;
  localparam int RUN_W  = $clog2(K_RUN + 1);
  localparam int OFS_W  = $clog2(OCTETS + 1);
  localparam logic [1:0] S_RST = 2'd0, S_PHY = 2'd1, S_CGS = 2'd2, S_DAT = 2'd3;
  localparam logic [1:0] L_INIT = 2'd0, L_CHK = 2'd1, L_DAT = 2'd2;

  logic [1:0]       st_q;
  logic [LANES-1:0] lane_sync;
  logic             all_phy, all_sync, rel_edge;

  assign all_phy  = &(phy_rdy | lane_off);
  assign all_sync = &(lane_sync | lane_off);
  assign rel_edge = subclass1 ? (lmfc_edge & sysref_seen) : frame_edge;

  always_ff @(posedge clk) begin
    if (rst || !link_en) st_q <= S_RST;
    else begin
      case (st_q)
        S_RST:   st_q <= S_PHY;
        S_PHY:   if (all_phy) st_q <= S_CGS;
        S_CGS:   if (all_sync && rel_edge) st_q <= S_DAT;
        default: st_q <= st_q;
      endcase
    end
  end

  assign link_state = st_q;
  assign data_valid = (st_q == S_DAT);
  assign align_en   = (st_q == S_CGS);
  assign sync_n     = link_mask | {LINKS{st_q == S_DAT}};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [1:0]       lst_q, lst_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic [LAT_W-1:0] lat_q;
    logic             done_q, has_nk;
    logic [OFS_W-1:0] first_nk;
    logic [OCTETS-1:0] is_k;

    always_comb begin
      for (int o = 0; o < OCTETS; o++)
        is_k[o] = beat_kflag[i*OCTETS+o] && (beat_data[i*BEAT_W+o*8 +: 8] == K_CODE);
    end

    always_comb begin
      lst_d = lst_q;
      run_d = run_q;
      has_nk = 1'b0;
      first_nk = '0;
      for (int o = 0; o < OCTETS; o++) begin
        if (is_k[o]) begin
          if (lst_d == L_INIT) begin
            lst_d = L_CHK;
            run_d = RUN_W'(1);
          end else if (lst_d == L_CHK) begin
            if (run_d == RUN_W'(K_RUN - 1)) lst_d = L_DAT;
            else run_d = run_d + 1'b1;
          end
        end else begin
          if (lst_d == L_CHK) lst_d = L_INIT;
          if (!has_nk) begin
            has_nk = 1'b1;
            first_nk = OFS_W'(o);
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst || !link_en || lane_off[i] || st_q == S_RST || st_q == S_PHY) begin
        lst_q <= L_INIT;
        run_q <= '0;
      end else if (st_q == S_CGS) begin
        lst_q <= lst_d;
        run_q <= run_d;
      end
    end

    always_ff @(posedge clk) begin
      if (rst || st_q != S_DAT) begin
        lat_q  <= '0;
        done_q <= 1'b0;
      end else if (!done_q) begin
        if (has_nk) begin
          lat_q  <= lat_q + LAT_W'(first_nk);
          done_q <= 1'b1;
        end else begin
          lat_q <= lat_q + LAT_W'(OCTETS);
        end
      end
    end

    assign lane_sync[i]             = (lst_q == L_DAT);
    assign lane_state[2*i +: 2]     = lst_q;
    assign lane_lat[LAT_W*i +: LAT_W] = lat_q;
  end
endmodule

// File: rtl/rx_link_ctrl_chk.sv
module rx_link_ctrl_chk #(
  parameter int LANES = 2,
  parameter int LINKS = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               link_en,
  input logic               subclass1,
  input logic               sysref_seen,
  input logic               lmfc_edge,
  input logic               frame_edge,
  input logic [LANES-1:0]   lane_off,
  input logic [LANES-1:0]   phy_rdy,
  input logic [LINKS-1:0]   link_mask,
  input logic [LINKS-1:0]   sync_n,
  input logic               align_en,
  input logic               data_valid,
  input logic [1:0]         link_state,
  input logic [LANES*2-1:0] lane_state
);
  AST_DISABLE_TO_RESET: assert property (@(posedge clk) disable iff (rst) !link_en |=> link_state == 2'd0); // R2
  AST_PHY_GATE: assert property (@(posedge clk) disable iff (rst) (link_state == 2'd2 && $past(link_state) == 2'd1) |-> $past(&(phy_rdy | lane_off))); // R3
  AST_SYNC_TOGETHER: assert property (@(posedge clk) disable iff (rst) ((sync_n | link_mask) == {LINKS{1'b1}}) || ((sync_n & ~link_mask) == '0)); // R4
  AST_SYNC_LOW_IN_ALIGN: assert property (@(posedge clk) disable iff (rst) align_en |-> ((sync_n & ~link_mask) == '0)); // R4
  AST_RELEASE_EDGE: assert property (@(posedge clk) disable iff (rst) $rose(data_valid) |-> $past(subclass1 ? (lmfc_edge & sysref_seen) : frame_edge)); // R7
  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (rst) (data_valid && link_en) |=> data_valid); // R8
  always_comb begin
    for (int i = 0; i < LANES; i++)
      AST_LANE_CODE: assert (rst || lane_state[2*i +: 2] != 2'd3); // R5
  end
endmodule

bind rx_link_ctrl rx_link_ctrl_chk #(.LANES(LANES), .LINKS(LINKS)) u_chk (.*);

// File: tb/test_rx_link_ctrl.sv
module test_rx_link_ctrl;
  localparam int LANES = 2, LINKS = 2, OCTETS = 4, LAT_W = 12;

  logic clk = 0, rst = 1, link_en = 0, subclass1 = 0, sysref_seen = 0, lmfc_edge = 0, frame_edge = 0;
  logic [LANES-1:0] lane_off = '0, phy_rdy = '0;
  logic [LANES*32-1:0] beat_data = '0;
  logic [LANES*4-1:0] beat_kflag = '0;
  logic [LINKS-1:0] link_mask = '0;
  logic [LINKS-1:0] sync_n;
  logic align_en, data_valid;
  logic [1:0] link_state;
  logic [LANES*2-1:0] lane_state;
  logic [LANES*LAT_W-1:0] lane_lat;

  rx_link_ctrl i_rx_link_ctrl (.*);

  always #4 clk = ~clk;

  typedef struct {
    logic [1:0] st; logic [3:0] ln; logic [LINKS-1:0] mask;
    bit chk_lat; logic [2*LAT_W-1:0] lat; string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic beat(input int lane, input logic [3:0] kmask);
    for (int o = 0; o < 4; o++) begin
      beat_data[lane*32+o*8 +: 8] = kmask[o] ? 8'hBC : 8'h5A;
      beat_kflag[lane*4+o] = kmask[o];
    end
  endtask

  task automatic cyc(input logic [1:0] st, input logic [1:0] l0, input logic [1:0] l1,
                     input string tag, input bit cl = 0, input int lat0 = 0, input int lat1 = 0);
    exp_t e;
    e.st = st; e.ln = {l1, l0}; e.mask = link_mask; e.chk_lat = cl;
    e.lat = {LAT_W'(lat1), LAT_W'(lat0)}; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    exp_t e;
    logic [8:0] act, ex;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        act = {link_state, lane_state, sync_n, data_valid, align_en};
        ex  = {e.st, e.ln, e.mask | {LINKS{e.st == 2'd3}}, e.st == 2'd3, e.st == 2'd2};
        checks++;
        if (act !== ex) begin
          fails++;
          $display("FAIL %s: {state,lanes,sync_n,valid,align} actual %b expected %b", e.tag, act, ex);
        end
        if (e.chk_lat) begin
          checks++;
          if (lane_lat !== e.lat) begin
            fails++;
            $display("FAIL %s: lane_lat actual %h expected %h", e.tag, lane_lat, e.lat);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    beat(0, 4'hF); beat(1, 4'hF); phy_rdy = 2'b11;
    cyc(0, 0, 0, "R1 reset");
    cyc(0, 0, 0, "R1 reset held");
    rst = 0;
    cyc(0, 0, 0, "R2 disabled ignores inputs");
    link_en = 1;
    cyc(1, 0, 0, "R2 enable to wait");
    phy_rdy = 2'b01;
    cyc(1, 0, 0, "R3 lane1 not ready");
    lane_off = 2'b10;
    cyc(2, 0, 0, "R3 R9 off lane skips phy check");
    lane_off = 2'b00; phy_rdy = 2'b11;
    beat(0, 4'b0111); beat(1, 4'b1000);
    cyc(2, 0, 1, "R5 broken run and run start");
    beat(0, 4'b1111); beat(1, 4'b0111);
    cyc(2, 2, 2, "R5 run across beats");
    beat(0, 4'b0000); beat(1, 4'b0000);
    cyc(2, 2, 2, "R6 no boundary yet, DATA lanes hold");
    frame_edge = 1;
    cyc(3, 2, 2, "R6 R8 release on frame edge");
    frame_edge = 0; beat(0, 4'b1111); beat(1, 4'b1100);
    cyc(3, 2, 2, "R8 valid holds");
    beat(0, 4'b0011);
    cyc(3, 2, 2, "R10 latency", 1, 6, 0);
    link_en = 0;
    cyc(0, 0, 0, "R2 disable from DATA");
    link_en = 1; subclass1 = 1; link_mask = 2'b01; beat(0, 4'hF); beat(1, 4'hF);
    cyc(1, 0, 0, "R2 re-enable");
    cyc(2, 0, 0, "R3 all ready");
    cyc(2, 2, 2, "R5 full comma beat");
    lmfc_edge = 1; frame_edge = 1;
    cyc(2, 2, 2, "R7 R4 held without sysref, masked line high");
    sysref_seen = 1; lmfc_edge = 0;
    cyc(2, 2, 2, "R7 frame edge ignored in subclass 1");
    lmfc_edge = 1;
    cyc(3, 2, 2, "R7 release on lmfc with sysref");
    lmfc_edge = 0; frame_edge = 0; link_en = 0;
    cyc(0, 0, 0, "R2 disable");
    link_en = 1; subclass1 = 0; link_mask = 2'b10;
    cyc(1, 0, 0, "R2 enable");
    cyc(2, 0, 0, "R3 to CGS");
    lane_off = 2'b01; frame_edge = 1;
    cyc(2, 0, 2, "R9 off lane held INIT");
    cyc(3, 0, 2, "R9 off lane excluded from release");
    rst = 1;
    cyc(0, 0, 0, "R1 reset from DATA");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule